// File: doc/BRIEF.md
# Protection FET Enable Arbiter

This block decides, every clock cycle, whether the charge and discharge high-side protection switches of a battery pack may be on. Three kinds of blocker can hold a channel off. The first is a fault latch that the block sets itself when a fault is flagged. The second is a host hold latch, set by a host command and released by another. The third is an external force-off pin, taken in through a synchronizer and acting only while it is asserted. A channel is enabled only when none of its blockers is present. A 2-bit mode field selects how fault recovery works: fully automatic, automatic with a host hold, or host-released only.

The discharge channel has one more decision to make: where its drive comes from. When the low-power follower option is configured and the pack is asleep, the discharge drive uses the battery-voltage follower. As soon as discharge current appears, the drive moves to the charge pump and stays there until sleep ends. A sticky alert flags every new fault for the host. A status word shows each channel's blockers. All pins are plain control and status levels or one-cycle pulses. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `fet_enable_arbiter`

## Requirements
- R1: If `fault_det[c]` is high at a rising edge, `fet_en[c]` is low after that edge and the channel's fault latch is set.
- R2: In mode 00 (autonomous), `recov_ok[c]` high with `fault_det[c]` low clears the fault latch at that edge. If no other blocker is present, `fet_en[c]` is high after the same edge.
- R3: A `host_off[c]` pulse sets the host latch and turns the channel off after that edge. The latch holds until a `host_rel[c]` pulse arrives. If both pulses arrive in the same cycle, the latch is set.
- R4: `force_off[c]` passes through a two-flop synchronizer. Its synchronized level appears in status after the second rising edge, and `fet_en[c]` reflects it after the third.
- R5: Removing one blocker re-enables a channel only if no other blocker (fault latch, host latch, synchronized pin) is still present.
- R6: In mode 01 (partially autonomous), a fault also sets the host latch. After recovery the channel stays off until `host_rel[c]`.
- R7: In modes 10 and 11 (manual), `recov_ok` is ignored. A fault sets the host latch, and only `host_rel[c]` with `fault_det[c]` low clears both latches.
- R8: `dsg_follow` is high after an edge at which `cfg_follow_en` and `sleep_mode` are high and no discharge current is held. Otherwise it is low.
- R9: `dsg_cur_det` high during sleep drives `dsg_follow` low after that edge. It stays low, even after the current indication drops, until `sleep_mode` has been low for an edge.
- R10: `pump_en` is high whenever either `fet_en` bit is high or `cfg_follow_en` is high, and low otherwise.
- R11: `alert` goes high after any edge at which a `fault_det` bit rises. It stays high until an `alert_clr` pulse. A new fault edge wins over a clear in the same cycle.
- R12: `chan_status[3c+0]` is the fault latch, `[3c+1]` the host latch and `[3c+2]` the synchronized pin of channel c (c=0 charge, c=1 discharge).
- R13: During reset, `fet_en`, `alert`, `dsg_follow` and `chan_status` are all zero. After the first edge out of reset, with no blockers, both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Recovery mode: 00 auto, 01 partial, 10/11 manual |
| cfg_follow_en | input | 1 | Enable battery-follower drive for discharge in sleep |
| fault_det | input | 2 | Per-channel fault flag, bit 0 charge, bit 1 discharge |
| recov_ok | input | 2 | Per-channel recovery-condition flag |
| host_off | input | 2 | Host force-off command pulse |
| host_rel | input | 2 | Host release command pulse |
| force_off | input | 2 | Asynchronous active-high force-off pins |
| sleep_mode | input | 1 | Device is in sleep |
| dsg_cur_det | input | 1 | Discharge current detected |
| alert_clr | input | 1 | Host clear pulse for the alert |
| fet_en | output | 2 | Gate-enable requests, bit 0 charge, bit 1 discharge |
| dsg_follow | output | 1 | 1 = discharge driven by battery follower, 0 = charge pump |
| pump_en | output | 1 | Charge-pump enable |
| alert | output | 1 | Sticky fault interrupt |
| chan_status | output | 6 | Per-channel blocker status (see R12) |

## Verification
The bench applies a host force-off and a release in the same cycle. A design that let the release win would re-enable a channel the host meant to hold. It counts the exact edge at which a synchronized pin reaches the enable. An off-by-one synchronizer would shift that edge, and a design using the raw pin would react two edges early. It runs fault recovery in each mode. A manual design that honoured `recov_ok`, or a partial design that skipped the host latch, would turn the channel back on too soon. It also drops the discharge-current flag while still asleep. A design without the hold would fall back to follower drive while current may still flow.

// File: rtl/fet_arb_pkg.sv
package fet_arb_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO = 2'b00,
    MODE_PART = 2'b01,
    MODE_MAN  = 2'b10,
    MODE_RSVD = 2'b11
  } ctl_mode_e;

  localparam int unsigned CH_CHG = 0;
  localparam int unsigned CH_DSG = 1;
  localparam int unsigned ST_W   = 3;

  function automatic logic mode_is_manual(ctl_mode_e m);
    return (m == MODE_MAN) || (m == MODE_RSVD);
  endfunction

  function automatic logic mode_auto_hold(ctl_mode_e m);
    return m != MODE_AUTO;
  endfunction
endpackage

// File: rtl/fet_pin_sync.sv
module fet_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= async_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fet_chan_ctrl.sv
module fet_chan_ctrl
  import fet_arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_mode_e mode_i,
  input  logic      fault_i,
  input  logic      recov_i,
  input  logic      hoff_i,
  input  logic      hrel_i,
  input  logic      pin_blk_i,
  output logic      en_o,
  output logic      fault_lat_o,
  output logic      host_lat_o
);
  logic fault_q, host_q, en_q;
  logic fault_n, host_n, en_n;
  logic manual;

  always_comb begin
    manual  = mode_is_manual(mode_i);
    fault_n = fault_q;
    if (fault_i)                           fault_n = 1'b1;
    else if (manual ? hrel_i : recov_i)    fault_n = 1'b0;
    host_n = host_q;
    if (hoff_i || (fault_i && mode_auto_hold(mode_i))) host_n = 1'b1;
    else if (hrel_i)                                   host_n = 1'b0;
    en_n = !(fault_n || host_n || pin_blk_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      host_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      fault_q <= fault_n;
      host_q  <= host_n;
      en_q    <= en_n;
    end
  end

  assign en_o        = en_q;
  assign fault_lat_o = fault_q;
  assign host_lat_o  = host_q;

  p_fault_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (!en_o && fault_lat_o));

  p_auto_recover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_AUTO && recov_i && !fault_i && !host_q && !hoff_i && !pin_blk_i) |=> en_o);

  p_host_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_q && !hrel_i) |=> (host_lat_o && !en_o));

  p_pin_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_blk_i |=> !en_o);

  p_manual_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_manual(mode_i) && fault_q && !hrel_i) |=> fault_lat_o);
endmodule

// File: rtl/fet_dsg_source.sv
module fet_dsg_source (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_follow_i,
  input  logic sleep_i,
  input  logic cur_i,
  output logic follow_o
);
  logic hold_q, follow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      follow_q <= 1'b0;
    end else begin
      hold_q   <= sleep_i ? (hold_q || cur_i) : 1'b0;
      follow_q <= cfg_follow_i && sleep_i && !cur_i && !hold_q;
    end
  end

  assign follow_o = follow_q;

  p_cur_to_pump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_i |=> !follow_o);

  p_hold_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && $past(sleep_i) && !follow_o && $past(cur_i)) |=> !follow_o);

  p_awake_pump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !follow_o);
endmodule

// File: rtl/fet_alert_ctrl.sv
module fet_alert_ctrl #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fault_i,
  input  logic              clr_i,
  output logic              alert_o
);
  logic [NUM_CH-1:0] prev_q;
  logic              alert_q;
  logic              new_edge;

  assign new_edge = |(fault_i & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      alert_q <= 1'b0;
    end else begin
      prev_q <= fault_i;
      if (new_edge)   alert_q <= 1'b1;
      else if (clr_i) alert_q <= 1'b0;
    end
  end

  assign alert_o = alert_q;

  p_alert_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    new_edge |=> alert_o);

  p_alert_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_o && !clr_i) |=> alert_o);
endmodule

// File: rtl/fet_enable_arbiter.sv
module fet_enable_arbiter
  import fet_arb_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned STAT_W     = NUM_CH * ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_follow_en,
  input  logic [NUM_CH-1:0] fault_det,
  input  logic [NUM_CH-1:0] recov_ok,
  input  logic [NUM_CH-1:0] host_off,
  input  logic [NUM_CH-1:0] host_rel,
  input  logic [NUM_CH-1:0] force_off,
  input  logic              sleep_mode,
  input  logic              dsg_cur_det,
  input  logic              alert_clr,
  output logic [NUM_CH-1:0] fet_en,
  output logic              dsg_follow,
  output logic              pump_en,
  output logic              alert,
  output logic [STAT_W-1:0] chan_status
);
  ctl_mode_e         mode;
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] fault_lat, host_lat;

  assign mode = ctl_mode_e'(cfg_mode);

  fet_pin_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(force_off), .sync_o(pin_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fet_chan_ctrl u_ch (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .fault_i(fault_det[c]), .recov_i(recov_ok[c]),
      .hoff_i(host_off[c]), .hrel_i(host_rel[c]),
      .pin_blk_i(pin_sync[c]),
      .en_o(fet_en[c]), .fault_lat_o(fault_lat[c]), .host_lat_o(host_lat[c])
    );
    assign chan_status[c*ST_W +: ST_W] = {pin_sync[c], host_lat[c], fault_lat[c]};
  end

  fet_dsg_source u_src (
    .clk(clk), .rst_n(rst_n), .cfg_follow_i(cfg_follow_en),
    .sleep_i(sleep_mode), .cur_i(dsg_cur_det), .follow_o(dsg_follow)
  );

  fet_alert_ctrl #(.NUM_CH(NUM_CH)) u_alert (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_det), .clr_i(alert_clr), .alert_o(alert)
  );

  assign pump_en = (|fet_en) || cfg_follow_en;

  p_follow_needs_pump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dsg_follow |-> pump_en);

  p_block_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fault_lat & ~fault_det & ~recov_ok & ~host_rel)) |=> (fet_en != {NUM_CH{1'b1}}));
endmodule

// File: tb/fet_enable_arbiter_tb.sv
module fet_enable_arbiter_tb;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_follow_en = 1'b0;
  logic [1:0] fault_det = '0, recov_ok = '0, host_off = '0, host_rel = '0, force_off = '0;
  logic       sleep_mode = 1'b0, dsg_cur_det = 1'b0, alert_clr = 1'b0;
  logic [1:0] fet_en;
  logic       dsg_follow, pump_en, alert;
  logic [5:0] chan_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fet_enable_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_follow_en(cfg_follow_en),
    .fault_det(fault_det), .recov_ok(recov_ok), .host_off(host_off), .host_rel(host_rel),
    .force_off(force_off), .sleep_mode(sleep_mode), .dsg_cur_det(dsg_cur_det),
    .alert_clr(alert_clr), .fet_en(fet_en), .dsg_follow(dsg_follow), .pump_en(pump_en),
    .alert(alert), .chan_status(chan_status)
  );

  // kind: 0 fet_en, 1 dsg_follow, 2 pump_en, 3 alert, 4 chan_status
  task automatic expect_after_edge(string tag, int kind, logic [7:0] v);
    exp_t e;
    e.tag = tag; e.kind = kind; e.val = v;
    sb_q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    exp_t e;
    logic [7:0] act;
    #1;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      case (e.kind)
        0: act = {6'd0, fet_en};
        1: act = {7'd0, dsg_follow};
        2: act = {7'd0, pump_en};
        3: act = {7'd0, alert};
        default: act = {2'd0, chan_status};
      endcase
      n_cmp++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%b expected=%b", e.tag, e.kind, act, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick();
    // R13 reset state
    expect_after_edge("R13 en", 0, 8'b00);
    expect_after_edge("R13 alert", 3, 8'd0);
    expect_after_edge("R13 follow", 1, 8'd0);
    expect_after_edge("R13 status", 4, 8'd0);
    tick();
    rst_n = 1'b1;
    expect_after_edge("R13 first enable", 0, 8'b11);
    expect_after_edge("R10 pump with enables", 2, 8'd1);
    tick();

    // R1 fault, R11 alert, R12 status
    fault_det = 2'b01;
    expect_after_edge("R1 chg off", 0, 8'b10);
    expect_after_edge("R11 alert set", 3, 8'd1);
    expect_after_edge("R12 fault bit", 4, 8'b000001);
    tick();
    expect_after_edge("R1 still off", 0, 8'b10);
    tick();
    // R2 autonomous recovery
    fault_det = 2'b00; recov_ok = 2'b01;
    expect_after_edge("R2 auto re-enable", 0, 8'b11);
    expect_after_edge("R2 status clear", 4, 8'd0);
    expect_after_edge("R11 alert sticky", 3, 8'd1);
    tick();
    recov_ok = 2'b00; alert_clr = 1'b1;
    expect_after_edge("R11 alert clear", 3, 8'd0);
    tick();
    // R11 set wins over clear
    fault_det = 2'b10;
    expect_after_edge("R11 set beats clear", 3, 8'd1);
    expect_after_edge("R1 dsg off", 0, 8'b01);
    tick();
    alert_clr = 1'b0; fault_det = 2'b00; recov_ok = 2'b10;
    expect_after_edge("R2 dsg re-enable", 0, 8'b11);
    tick();
    recov_ok = 2'b00; alert_clr = 1'b1;
    tick();
    alert_clr = 1'b0;

    // R3 host latch
    host_off = 2'b01;
    expect_after_edge("R3 host off", 0, 8'b10);
    expect_after_edge("R12 host bit", 4, 8'b000010);
    tick();
    host_off = 2'b00;
    expect_after_edge("R3 hold", 0, 8'b10);
    tick();
    host_off = 2'b01; host_rel = 2'b01;
    expect_after_edge("R3 off beats release", 0, 8'b10);
    tick();
    host_off = 2'b00;
    expect_after_edge("R3 release", 0, 8'b11);
    expect_after_edge("R3 status cleared", 4, 8'd0);
    tick();
    host_rel = 2'b00;

    // R4 pin synchronizer latency
    force_off = 2'b10;
    tick();
    expect_after_edge("R4 sync status", 4, 8'b100000);
    expect_after_edge("R4 not yet", 0, 8'b11);
    tick();
    expect_after_edge("R4 blocked", 0, 8'b01);
    tick();
    // R5 fault recovered while pin still held
    fault_det = 2'b10;
    tick();
    fault_det = 2'b00; recov_ok = 2'b10;
    expect_after_edge("R5 pin keeps off", 0, 8'b01);
    tick();
    recov_ok = 2'b00; force_off = 2'b00;
    tick();
    expect_after_edge("R5 pin status gone", 4, 8'b000000);
    expect_after_edge("R5 still off", 0, 8'b01);
    tick();
    expect_after_edge("R5 released", 0, 8'b11);
    tick();
    alert_clr = 1'b1;
    tick();
    alert_clr = 1'b0;

    // R6 partial mode
    cfg_mode = 2'b01; fault_det = 2'b01;
    expect_after_edge("R6 both latches", 4, 8'b000011);
    tick();
    fault_det = 2'b00; recov_ok = 2'b01;
    expect_after_edge("R6 host latch stays", 4, 8'b000010);
    expect_after_edge("R6 still off", 0, 8'b10);
    tick();
    recov_ok = 2'b00; host_rel = 2'b01;
    expect_after_edge("R6 released", 0, 8'b11);
    tick();
    host_rel = 2'b00;

    // R7 manual (reserved code)
    cfg_mode = 2'b11; fault_det = 2'b10;
    expect_after_edge("R7 latched", 4, 8'b011000);
    tick();
    fault_det = 2'b00; recov_ok = 2'b10;
    expect_after_edge("R7 recov ignored", 4, 8'b011000);
    expect_after_edge("R7 still off", 0, 8'b01);
    tick();
    recov_ok = 2'b00; host_rel = 2'b10;
    expect_after_edge("R7 release clears", 4, 8'd0);
    expect_after_edge("R7 on", 0, 8'b11);
    tick();
    host_rel = 2'b00; cfg_mode = 2'b00; alert_clr = 1'b1;
    tick();
    alert_clr = 1'b0;

    // R8 / R9 follower drive
    cfg_follow_en = 1'b1; sleep_mode = 1'b1;
    expect_after_edge("R8 follower", 1, 8'd1);
    tick();
    dsg_cur_det = 1'b1;
    expect_after_edge("R9 to pump", 1, 8'd0);
    tick();
    dsg_cur_det = 1'b0;
    expect_after_edge("R9 hold in sleep", 1, 8'd0);
    tick();
    sleep_mode = 1'b0;
    expect_after_edge("R8 awake", 1, 8'd0);
    tick();
    sleep_mode = 1'b1;
    expect_after_edge("R9 hold cleared", 1, 8'd1);
    tick();
    cfg_follow_en = 1'b0;
    expect_after_edge("R8 option off", 1, 8'd0);
    tick();
    sleep_mode = 1'b0;

    // R10 pump enable
    host_off = 2'b11;
    expect_after_edge("R10 all off", 0, 8'b00);
    expect_after_edge("R10 pump off", 2, 8'd0);
    tick();
    host_off = 2'b00; cfg_follow_en = 1'b1;
    expect_after_edge("R10 pump by option", 2, 8'd1);
    tick();
    cfg_follow_en = 1'b0; host_rel = 2'b01;
    expect_after_edge("R10 pump by chg", 2, 8'd1);
    expect_after_edge("R10 chg on", 0, 8'b01);
    tick();
    host_rel = 2'b00;
    tick();
    tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule